// File: doc/BRIEF.md
# Unified Issue Window and Retirement Buffer

This block is the instruction window of an out-of-order core. A single circular buffer of entries does two jobs: each entry first waits as a reservation station until its two register operands are available, and then stays as a retirement slot until every older instruction has left. Dispatch places one decoded instruction per cycle at the tail. A rename table, held inside the block, converts the two architectural source registers into tags that name the in-flight entries producing them. Every cycle the oldest entry with both operands ready goes to a functional unit. The result then comes back on a writeback port, which wakes up the waiting consumers.

The head entry leaves once its result has come back. The retire port carries the destination register and the value for the architectural register file. When a branch turns out to be mispredicted, the core names the branch's slot on the flush port. Everything younger than that slot disappears, the tail moves to the slot just after it, and the rename table is rebuilt from the entries that remain. Loads and stores hold an entry here only for their address computation. Memory ordering, the functional units and the caches live elsewhere.

Top module: `rsrob_unit`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, and `iss_valid` and `ret_valid` are both 0.
- R2: An accepted dispatch goes into slot `disp_tag`, which is the tail, and the tail then advances by one modulo 16. A source is ready at dispatch in three cases: no in-flight entry writes that register; the newest such entry has already completed; or that entry's writeback arrives in the same cycle.
- R3: In every cycle that any entry is ready, `iss_valid` is 1 and `iss_tag` names the ready entry nearest the head. The earliest an entry can issue is the cycle after its dispatch, and it issues only once.
- R4: A writeback with tag T marks every waiting source that refers to T as ready. A consumer whose last missing operand was T can issue in the cycle after that writeback.
- R5: A ready younger entry issues while an older entry is still waiting for an operand.
- R6: The head entry retires in the cycle after its writeback. `ret_tag`, `ret_dst`, `ret_has_dst` and `ret_data` carry its slot, its destination and its result. A completed entry does not retire while any older entry is incomplete.
- R7: The buffer holds 16 entries. When all 16 are occupied, `disp_ready` is 0 and a `disp_valid` pulse is ignored: the tail does not move and no extra entry ever retires.
- R8: A `flush_valid` pulse with slot B discards every entry younger than B. The next dispatch slot becomes B+1, a dispatch in the flush cycle is ignored, and a discarded slot never retires.
- R9: A retiring entry removes its rename mapping only if it is still the newest writer of its register. After a flush, each register maps to the newest surviving writer, or to the register file if no writer survives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_has_dst | input | 1 | Instruction writes a register |
| disp_dst | input | 3 | Destination architectural register |
| disp_src1 | input | 3 | First source architectural register |
| disp_src2 | input | 3 | Second source architectural register |
| disp_ready | output | 1 | Dispatch accepted this cycle if requested |
| disp_tag | output | 4 | Slot the next dispatch takes |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_tag | output | 4 | Slot of the issued entry |
| wb_valid | input | 1 | Result broadcast |
| wb_tag | input | 4 | Slot whose result is broadcast |
| wb_data | input | 32 | Result value |
| flush_valid | input | 1 | Mispredicted branch detected |
| flush_tag | input | 4 | Slot of the mispredicted branch |
| ret_valid | output | 1 | Head entry retires this cycle |
| ret_tag | output | 4 | Slot of the retiring entry |
| ret_has_dst | output | 1 | Retiring entry writes a register |
| ret_dst | output | 3 | Register file write address |
| ret_data | output | 32 | Register file write value |

## Verification
The risky overlap is a dispatch and the writeback of that dispatch's producer landing in the same cycle. The new entry reads its readiness from the table while the producer is only just completing, so it could miss the broadcast and wait forever. The bench drives a consumer's dispatch in exactly the cycle in which its producer's result returns. It then requires the consumer on the issue port in the very next cycle and the producer on the retire port alongside it. A second overlap is a flush together with a dispatch: the bench judges it through the next `disp_tag` and through a later consumer, which must wait on the older surviving writer.

// File: rtl/rsrob_pkg.sv
// Shared definitions for the unified issue window / retirement buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package rsrob_pkg;

    // Default geometry of the window.
    localparam int unsigned RB_DEPTH_DEF = 16;
    localparam int unsigned RB_ARCH_DEF  = 8;
    localparam int unsigned RB_DATA_DEF  = 32;

    // Per-entry life-cycle flags.
    typedef struct packed {
        logic valid;    // slot holds an in-flight instruction
        logic issued;   // sent to a functional unit
        logic done;     // result has come back
        logic has_dst;  // writes an architectural register
    } ent_flags_t;

endpackage

// File: rtl/rsrob_oldest_pick.sv
// Picks the requesting slot nearest the head of a circular buffer.
// Assumes: N is a power of two; age of slot i is (i - head) mod N.
module rsrob_oldest_pick #(
    parameter  int unsigned N  = 16,
    localparam int unsigned PW = $clog2(N)
) (
    input  logic [PW-1:0] head,
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [PW-1:0] sel
);

    // Walk from the youngest age down so the oldest request is the last write.
    always_comb begin
        logic [PW-1:0] idx;
        any = |req;
        sel = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = head + PW'(k);
            if (req[idx]) sel = idx;
        end
    end

    // The chosen slot must be one that actually asked.
    always_comb begin
        if (any) begin
            assert_pick_is_ready_R3: assert (req[sel]);
        end
    end

endmodule

// File: rtl/rsrob_rename_map.sv
// Maps each architectural register to its newest in-flight writer.
// Assumes: ARCH_REGS and DEPTH are powers of two; set and rebuild never
// arrive together (dispatch is blocked during a flush).
module rsrob_rename_map #(
    parameter  int unsigned DEPTH     = 16,
    parameter  int unsigned ARCH_REGS = 8,
    localparam int unsigned PW        = $clog2(DEPTH),
    localparam int unsigned AW        = $clog2(ARCH_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            look_a,
    input  logic [AW-1:0]            look_b,
    output logic                     hit_a,
    output logic [PW-1:0]            tag_a,
    output logic                     hit_b,
    output logic [PW-1:0]            tag_b,
    input  logic                     set_en,
    input  logic [AW-1:0]            set_reg,
    input  logic [PW-1:0]            set_tag,
    input  logic                     drop_en,
    input  logic [AW-1:0]            drop_reg,
    input  logic [PW-1:0]            drop_tag,
    input  logic                     rebuild_en,
    input  logic [PW-1:0]            head,
    input  logic [DEPTH-1:0]         keep,
    input  logic [DEPTH-1:0]         has_dst,
    input  logic [DEPTH-1:0][AW-1:0] dst
);

    logic          map_vld [ARCH_REGS];
    logic [PW-1:0] map_tag [ARCH_REGS];
    logic          rb_vld  [ARCH_REGS];
    logic [PW-1:0] rb_tag  [ARCH_REGS];

    // Source lookups read the table before this cycle's update.
    assign hit_a = map_vld[look_a];
    assign tag_a = map_tag[look_a];
    assign hit_b = map_vld[look_b];
    assign tag_b = map_tag[look_b];

    // Recompute every mapping from survivors, oldest to newest so newest wins.
    always_comb begin
        logic [PW-1:0] idx;
        for (int r = 0; r < ARCH_REGS; r++) begin
            rb_vld[r] = 1'b0;
            rb_tag[r] = '0;
            for (int age = 0; age < DEPTH; age++) begin
                idx = head + PW'(age);
                if (keep[idx] && has_dst[idx] && dst[idx] == AW'(r)) begin
                    rb_vld[r] = 1'b1;
                    rb_tag[r] = idx;
                end
            end
        end
    end

    // Table update: rebuild on flush, otherwise conditional drop then new writer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ARCH_REGS; r++) map_vld[r] <= 1'b0;
        end else if (rebuild_en) begin
            for (int r = 0; r < ARCH_REGS; r++) begin
                map_vld[r] <= rb_vld[r];
                map_tag[r] <= rb_tag[r];
            end
        end else begin
            if (drop_en && map_vld[drop_reg] && map_tag[drop_reg] == drop_tag)
                map_vld[drop_reg] <= 1'b0;
            if (set_en) begin
                map_vld[set_reg] <= 1'b1;
                map_tag[set_reg] <= set_tag;
            end
        end
    end

    // A new writer becomes the visible producer of its register.
    assert_map_newest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !rebuild_en) |=>
            (map_vld[$past(set_reg)] && map_tag[$past(set_reg)] == $past(set_tag)));

    // Retiring an older writer leaves a newer writer's mapping in place.
    assert_keep_younger_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_en && !set_en && !rebuild_en && map_vld[drop_reg] &&
         map_tag[drop_reg] != drop_tag) |=> map_vld[$past(drop_reg)]);

endmodule

// File: rtl/rsrob_unit.sv
// Unified reservation-station / reorder buffer. One dispatch, one issue,
// one writeback and one retirement per cycle; flush rolls back to a branch.
// Assumes: DEPTH and ARCH_REGS are powers of two; writebacks only name live
// slots; flush_tag names a live slot; dispatch is held off while flushing.
module rsrob_unit
    import rsrob_pkg::*;
#(
    parameter  int unsigned DEPTH     = RB_DEPTH_DEF,
    parameter  int unsigned ARCH_REGS = RB_ARCH_DEF,
    parameter  int unsigned DATA_W    = RB_DATA_DEF,
    localparam int unsigned PW        = $clog2(DEPTH),
    localparam int unsigned AW        = $clog2(ARCH_REGS),
    localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic              disp_has_dst,
    input  logic [AW-1:0]     disp_dst,
    input  logic [AW-1:0]     disp_src1,
    input  logic [AW-1:0]     disp_src2,
    output logic              disp_ready,
    output logic [PW-1:0]     disp_tag,
    output logic              iss_valid,
    output logic [PW-1:0]     iss_tag,
    input  logic              wb_valid,
    input  logic [PW-1:0]     wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              flush_valid,
    input  logic [PW-1:0]     flush_tag,
    output logic              ret_valid,
    output logic [PW-1:0]     ret_tag,
    output logic              ret_has_dst,
    output logic [AW-1:0]     ret_dst,
    output logic [DATA_W-1:0] ret_data
);

    ent_flags_t          flg    [DEPTH];
    logic [AW-1:0]       e_dst  [DEPTH];
    logic [PW-1:0]       e_tag_a[DEPTH];
    logic [PW-1:0]       e_tag_b[DEPTH];
    logic                e_rdy_a[DEPTH];
    logic                e_rdy_b[DEPTH];
    logic [DATA_W-1:0]   e_data [DEPTH];

    logic [PW-1:0]       head, tail;
    logic [CW-1:0]       count, cnt_nxt;
    logic                accept, do_ret;
    logic [DEPTH-1:0]    ready_v, keep_v, has_dst_v;
    logic [DEPTH-1:0][AW-1:0] dst_v;
    logic                hit_a, hit_b, new_rdy_a, new_rdy_b;
    logic [PW-1:0]       map_a, map_b, flush_age;

    // Handshake and retirement decisions for this cycle.
    assign disp_ready = (count != CW'(DEPTH)) && !flush_valid;
    assign accept     = disp_valid && disp_ready;
    assign disp_tag   = tail;
    assign do_ret     = flg[head].valid && flg[head].done;
    assign ret_valid  = do_ret;
    assign ret_tag    = head;
    assign ret_has_dst = flg[head].has_dst;
    assign ret_dst    = e_dst[head];
    assign ret_data   = e_data[head];
    assign flush_age  = flush_tag - head;

    // Per-slot request, survivor and destination vectors.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [PW-1:0] age;
        assign age          = PW'(g) - head;
        assign ready_v[g]   = flg[g].valid && !flg[g].issued && e_rdy_a[g] && e_rdy_b[g];
        assign has_dst_v[g] = flg[g].valid && flg[g].has_dst;
        assign dst_v[g]     = e_dst[g];
        assign keep_v[g]    = flg[g].valid && (age <= flush_age) &&
                              !(do_ret && head == PW'(g));
    end

    rsrob_oldest_pick #(.N(DEPTH)) u_pick (
        .head (head),
        .req  (ready_v),
        .any  (iss_valid),
        .sel  (iss_tag)
    );

    rsrob_rename_map #(.DEPTH(DEPTH), .ARCH_REGS(ARCH_REGS)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_a     (disp_src1),
        .look_b     (disp_src2),
        .hit_a      (hit_a),
        .tag_a      (map_a),
        .hit_b      (hit_b),
        .tag_b      (map_b),
        .set_en     (accept && disp_has_dst),
        .set_reg    (disp_dst),
        .set_tag    (tail),
        .drop_en    (do_ret && flg[head].has_dst),
        .drop_reg   (e_dst[head]),
        .drop_tag   (head),
        .rebuild_en (flush_valid),
        .head       (head),
        .keep       (keep_v),
        .has_dst    (has_dst_v),
        .dst        (dst_v)
    );

    // Operand readiness at dispatch, including a same-cycle result broadcast.
    always_comb begin
        new_rdy_a = !hit_a || flg[map_a].done || (wb_valid && wb_tag == map_a);
        new_rdy_b = !hit_b || flg[map_b].done || (wb_valid && wb_tag == map_b);
    end

    // Occupancy after this cycle's retirement, dispatch or rollback.
    always_comb begin
        if (flush_valid)
            cnt_nxt = CW'(flush_tag - head) + CW'(1) - CW'(do_ret);
        else
            cnt_nxt = count + CW'(accept) - CW'(do_ret);
    end

    // Pointer and per-entry state update; later writes take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) flg[i] <= '0;
        end else begin
            head  <= head + PW'(do_ret);
            tail  <= flush_valid ? PW'(flush_tag + 1'b1) : tail + PW'(accept);
            count <= cnt_nxt;
            for (int i = 0; i < DEPTH; i++) begin
                if (wb_valid && wb_tag == e_tag_a[i]) e_rdy_a[i] <= 1'b1;
                if (wb_valid && wb_tag == e_tag_b[i]) e_rdy_b[i] <= 1'b1;
                if (iss_valid && iss_tag == PW'(i)) flg[i].issued <= 1'b1;
                if (wb_valid && wb_tag == PW'(i)) begin
                    flg[i].done <= 1'b1;
                    e_data[i]   <= wb_data;
                end
                if (do_ret && head == PW'(i)) flg[i].valid <= 1'b0;
                if (flush_valid && !keep_v[i]) flg[i].valid <= 1'b0;
                if (accept && tail == PW'(i)) begin
                    flg[i]     <= '{valid: 1'b1, issued: 1'b0, done: 1'b0,
                                    has_dst: disp_has_dst};
                    e_dst[i]   <= disp_dst;
                    e_tag_a[i] <= map_a;
                    e_tag_b[i] <= map_b;
                    e_rdy_a[i] <= new_rdy_a;
                    e_rdy_b[i] <= new_rdy_b;
                end
            end
        end
    end

    // A full window refuses dispatch.
    assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !disp_ready);

    // Occupancy never exceeds the slot count.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // An issued slot is not offered again in the following cycle.
    assert_issue_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !(iss_valid && iss_tag == $past(iss_tag)));

    // Retirement walks the head forward by exactly one slot.
    assert_retire_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> head == PW'($past(head) + 1'b1));

    // Rollback puts the tail just past the mispredicted branch.
    assert_flush_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> tail == PW'($past(flush_tag) + 1'b1));

endmodule

// File: tb/rsrob_unit_bench.sv
// Directed bench for rsrob_unit: one task per scenario, each self-checking.
module rsrob_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0, disp_has_dst = 1'b0;
    logic [2:0]  disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
    logic        disp_ready;
    logic [3:0]  disp_tag;
    logic        iss_valid;
    logic [3:0]  iss_tag;
    logic        wb_valid = 1'b0;
    logic [3:0]  wb_tag = '0;
    logic [31:0] wb_data = '0;
    logic        flush_valid = 1'b0;
    logic [3:0]  flush_tag = '0;
    logic        ret_valid, ret_has_dst;
    logic [3:0]  ret_tag;
    logic [2:0]  ret_dst;
    logic [31:0] ret_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rsrob_unit u_rsrob_unit (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_has_dst(disp_has_dst), .disp_dst(disp_dst),
        .disp_src1(disp_src1), .disp_src2(disp_src2),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .iss_valid(iss_valid), .iss_tag(iss_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_has_dst(ret_has_dst),
        .ret_dst(ret_dst), .ret_data(ret_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Advance one cycle; inputs change 2 ns after the edge, checks 1 ns later.
    task automatic nxt();
        @(posedge clk);
        #2;
        disp_valid = 1'b0;
        wb_valid = 1'b0;
        flush_valid = 1'b0;
    endtask

    task automatic drv_disp(input logic hd, input int d, input int s1, input int s2);
        disp_valid = 1'b1;
        disp_has_dst = hd;
        disp_dst = 3'(d);
        disp_src1 = 3'(s1);
        disp_src2 = 3'(s2);
    endtask

    task automatic drv_wb(input logic [3:0] t, input logic [31:0] d);
        wb_valid = 1'b1;
        wb_tag = t;
        wb_data = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) nxt();
    endtask

    task automatic t_reset();
        #1;
        chk("R1", "disp_ready", 32'(disp_ready), 1);
        chk("R1", "disp_tag", 32'(disp_tag), 0);
        chk("R1", "iss_valid", 32'(iss_valid), 0);
        chk("R1", "ret_valid", 32'(ret_valid), 0);
        nxt();
    endtask

    task automatic t_basic();
        logic [3:0] t0;
        drv_disp(1, 1, 2, 3); #1; t0 = disp_tag;
        chk("R2", "first slot", 32'(t0), 0); nxt();
        #1; chk("R3", "iss_valid", 32'(iss_valid), 1);
        chk("R3", "iss_tag", 32'(iss_tag), 32'(t0));
        chk("R6", "no early retire", 32'(ret_valid), 0); nxt();
        drv_wb(t0, 32'hA5); #1; chk("R6", "retire waits wb", 32'(ret_valid), 0); nxt();
        #1; chk("R6", "ret_valid", 32'(ret_valid), 1);
        chk("R6", "ret_tag", 32'(ret_tag), 32'(t0));
        chk("R6", "ret_dst", 32'(ret_dst), 1);
        chk("R6", "ret_has_dst", 32'(ret_has_dst), 1);
        chk("R6", "ret_data", ret_data, 32'hA5); nxt();
        #1; chk("R6", "single retire", 32'(ret_valid), 0);
        chk("R2", "tail advanced", 32'(disp_tag), 1); nxt();
    endtask

    task automatic t_wake();
        logic [3:0] tp, tc;
        drv_disp(1, 4, 2, 3); #1; tp = disp_tag; nxt();
        drv_disp(1, 5, 4, 0); #1; tc = disp_tag;
        chk("R3", "producer issues", 32'(iss_tag), 32'(tp)); nxt();
        #1; chk("R4", "consumer waits", 32'(iss_valid), 0); nxt();
        drv_wb(tp, 32'h11); #1; chk("R4", "no issue in wb cycle", 32'(iss_valid), 0); nxt();
        #1; chk("R4", "woken issue", 32'(iss_valid), 1);
        chk("R4", "woken tag", 32'(iss_tag), 32'(tc));
        chk("R6", "producer retires", 32'(ret_tag), 32'(tp)); nxt();
        drv_wb(tc, 32'h22); #1; chk("R6", "head not done", 32'(ret_valid), 0); nxt();
        #1; chk("R6", "consumer data", ret_data, 32'h22); nxt();
    endtask

    task automatic t_bypass();
        logic [3:0] tp, tc;
        drv_disp(1, 6, 1, 2); #1; tp = disp_tag; nxt();
        nxt();
        drv_wb(tp, 32'h33); drv_disp(1, 7, 6, 6); #1; tc = disp_tag; nxt();
        #1; chk("R2", "same-cycle wb bypass issue", 32'(iss_valid), 1);
        chk("R2", "bypass tag", 32'(iss_tag), 32'(tc));
        chk("R6", "producer retires alongside", 32'(ret_tag), 32'(tp)); nxt();
        drv_wb(tc, 32'h44); nxt();
        #1; chk("R6", "bypass consumer retires", 32'(ret_tag), 32'(tc)); nxt();
    endtask

    task automatic t_done_src();
        logic [3:0] th, tp, tc;
        drv_disp(1, 0, 1, 2); #1; th = disp_tag; nxt();
        drv_disp(1, 2, 1, 3); #1; tp = disp_tag; nxt();
        nxt();
        drv_wb(tp, 32'h55); nxt();
        drv_disp(1, 3, 2, 2); #1; tc = disp_tag;
        chk("R6", "done entry behind busy head", 32'(ret_valid), 0); nxt();
        #1; chk("R2", "completed producer gives ready", 32'(iss_tag), 32'(tc));
        chk("R2", "completed producer issue", 32'(iss_valid), 1); nxt();
        drv_wb(th, 32'h1); nxt();
        #1; chk("R6", "head first", 32'(ret_tag), 32'(th)); nxt();
        drv_wb(tc, 32'h2); #1;
        chk("R6", "then producer", 32'(ret_tag), 32'(tp));
        chk("R6", "producer data", ret_data, 32'h55); nxt();
        #1; chk("R6", "then consumer", 32'(ret_tag), 32'(tc)); nxt();
    endtask

    task automatic t_ooo();
        logic [3:0] tp, tc, td;
        drv_disp(1, 6, 1, 2); #1; tp = disp_tag; nxt();
        drv_disp(1, 1, 6, 6); #1; tc = disp_tag; nxt();
        drv_disp(1, 2, 3, 4); #1; td = disp_tag;
        chk("R5", "blocked consumer idle", 32'(iss_valid), 0); nxt();
        #1; chk("R5", "younger issues first", 32'(iss_tag), 32'(td));
        chk("R5", "younger issue valid", 32'(iss_valid), 1); nxt();
        drv_wb(td, 32'h7); nxt();
        drv_wb(tp, 32'h8); #1; chk("R6", "young done waits", 32'(ret_valid), 0); nxt();
        #1; chk("R4", "consumer issue", 32'(iss_tag), 32'(tc));
        chk("R6", "oldest retires", 32'(ret_tag), 32'(tp)); nxt();
        drv_wb(tc, 32'h9); #1; chk("R6", "order kept", 32'(ret_valid), 0); nxt();
        #1; chk("R6", "middle retires", 32'(ret_tag), 32'(tc)); nxt();
        #1; chk("R6", "young retires last", 32'(ret_tag), 32'(td)); nxt();
    endtask

    task automatic t_oldest();
        logic [3:0] tp, tx, ty;
        drv_disp(1, 5, 0, 0); #1; tp = disp_tag; nxt();
        drv_disp(1, 1, 5, 5); #1; tx = disp_tag; nxt();
        drv_disp(1, 2, 5, 0); #1; ty = disp_tag; nxt();
        drv_wb(tp, 32'h3); nxt();
        #1; chk("R3", "oldest ready first", 32'(iss_tag), 32'(tx)); nxt();
        #1; chk("R3", "next oldest", 32'(iss_tag), 32'(ty)); nxt();
        drv_wb(tx, 0); nxt();
        drv_wb(ty, 0); nxt();
        idle(4);
    endtask

    task automatic t_rename();
        logic [3:0] p1, p2, tc, te;
        drv_disp(1, 3, 0, 0); #1; p1 = disp_tag; nxt();
        drv_disp(1, 3, 0, 0); #1; p2 = disp_tag; nxt();
        drv_wb(p1, 32'h5); nxt();
        #1; chk("R6", "older writer retires", 32'(ret_tag), 32'(p1)); nxt();
        drv_disp(1, 4, 3, 3); #1; tc = disp_tag; nxt();
        #1; chk("R9", "mapping kept for newer writer", 32'(iss_valid), 0); nxt();
        drv_wb(p2, 32'h6); nxt();
        #1; chk("R9", "waits on newer writer", 32'(iss_tag), 32'(tc)); nxt();
        drv_wb(tc, 0); drv_disp(0, 0, 3, 3); #1; te = disp_tag; nxt();
        #1; chk("R9", "mapping dropped by newest", 32'(iss_tag), 32'(te));
        chk("R9", "free register ready", 32'(iss_valid), 1); nxt();
        drv_wb(te, 0); nxt();
        idle(4);
    endtask

    task automatic t_full();
        logic [3:0] base;
        int rets = 0;
        #1; base = disp_tag;
        for (int k = 0; k < 16; k++) begin
            drv_disp(0, 0, 0, 0); nxt();
        end
        #1; chk("R7", "full refuses", 32'(disp_ready), 0);
        drv_disp(0, 0, 0, 0); nxt();
        #1; chk("R7", "tail held when full", 32'(disp_tag), 32'(base));
        for (int k = 0; k < 16; k++) begin
            drv_wb(4'(base + 4'(k)), 32'(k)); #1;
            if (ret_valid) rets++;
            nxt();
        end
        for (int k = 0; k < 20; k++) begin
            #1; if (ret_valid) rets++;
            nxt();
        end
        chk("R7", "retire count", 32'(rets), 16);
        #1; chk("R7", "ready after drain", 32'(disp_ready), 1); nxt();
    endtask

    task automatic t_flush();
        logic [3:0] to, tb, ty2, tz;
        drv_disp(1, 7, 0, 0); #1; to = disp_tag; nxt();
        drv_disp(0, 0, 0, 0); #1; tb = disp_tag; nxt();
        drv_disp(1, 7, 0, 0); nxt();
        drv_disp(1, 7, 7, 7); #1; ty2 = disp_tag; nxt();
        flush_valid = 1'b1; flush_tag = tb; drv_disp(1, 1, 0, 0);
        #1; chk("R8", "no dispatch during flush", 32'(disp_ready), 0); nxt();
        #1; chk("R8", "tail after branch", 32'(disp_tag), 32'(4'(tb + 4'd1)));
        drv_disp(1, 2, 7, 7); tz = disp_tag; nxt();
        drv_wb(ty2, 32'h99); #1;
        chk("R9", "waits on surviving writer", 32'(iss_valid), 0); nxt();
        drv_wb(tb, 0); nxt();
        drv_wb(to, 32'h77); #1; chk("R9", "still waiting", 32'(iss_valid), 0); nxt();
        #1; chk("R9", "survivor wakes consumer", 32'(iss_tag), 32'(tz));
        chk("R6", "survivor retires", 32'(ret_tag), 32'(to));
        chk("R6", "survivor data", ret_data, 32'h77); nxt();
        #1; chk("R6", "branch retires", 32'(ret_tag), 32'(tb)); nxt();
        drv_wb(tz, 32'h5A); #1; chk("R8", "no retire of new slot early", 32'(ret_valid), 0); nxt();
        #1; chk("R8", "post-flush entry retires", ret_data, 32'h5A); nxt();
        #1; chk("R8", "discarded slot never retires", 32'(ret_valid), 0); nxt();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1;
        t_reset();
        t_basic();
        t_wake();
        t_bypass();
        t_done_src();
        t_ooo();
        t_oldest();
        t_rename();
        t_full();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule